// File: doc/BRIEF.md
# Port-Selectable Edge Interrupt Unit

This block turns pin activity into latched interrupt flags. It has a fixed number of interrupt lines. Line `x` always watches pin `x`, and software chooses which of several equal-width input ports supplies that pin. Each line samples its pin through a synchronizer and compares each new sample with the one before it. A rising edge, a falling edge or both can be armed per line. An armed edge latches a sticky flag. The single interrupt output is asserted while any flag whose enable bit is set is high.

Software reaches the block over a plain single-cycle register bus. Writes take effect at the clock edge, and reads are combinational from the address. There are two packed select words, rise-enable, fall-enable and interrupt-enable masks, a flag view, write-one-to-set and write-one-to-clear flag aliases, and a sense-control word. Bit 0 of the sense-control word gates edge detection for interrupts. Bit 1 gates a per-line level output meant for an event-routing fabric. When a select field changes, the block reloads the line's edge history, so a change of source alone never raises a flag.

Top module: `extirq_unit`

## Requirements
- R1: After reset every readable register reads zero, `irq` is low and `evt_level` is zero.
- R2: Select fields are 4 bits. The field for line `l` (0..7) is at bits `4*l+3:4*l` of the word at 0x100. The field for line `l` (8..15) is at bits `4*(l-8)+3:4*(l-8)` of the word at 0x104. Rise enable (0x108), fall enable (0x10C), interrupt enable (0x110) and sense control (0x124, bits 1:0) read back as written. Flags read at 0x114, and a write to 0x114 is ignored.
- R3: Select code `p` in 0..5 connects line `x` to `pins_in[16*p + x]`. A low-to-high change on that pin with the line's rise-enable bit set sets flag `x`, visible on the third rising clock edge after the pin changes.
- R4: A high-to-low change on the selected pin with the line's fall-enable bit set sets the flag with the same latency.
- R5: An edge whose direction-enable bit for that line is clear leaves the flag unchanged.
- R6: Select codes 6..15 connect no pin, and that line's flag is never set by hardware.
- R7: Rewriting a select field, even to a port whose pin level differs from the old source, sets no flag.
- R8: While sense-control bit 0 is clear, no edge sets a flag.
- R9: Writing to 0x118 sets each flag whose data bit is one, and writing to 0x11C clears each flag whose data bit is one. Zero bits leave flags as they were.
- R10: When a detected edge and a clear write hit the same flag in the same cycle, the flag ends up set.
- R11: `irq` is high exactly when some flag and its interrupt-enable bit are both one. Flags latch even while their enable bit is clear.
- R12: `evt_level[x]` equals the synchronized level of line `x`'s selected pin while sense-control bit 1 is set, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | 96 | Six 16-bit ports, port `p` pin `x` at bit `16*p+x` |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR of enabled flags |
| evt_level | output | 16 | Per-line synchronized pin level, gated by sense bit 1 |

## Verification
A stale edge history shows up as a flag set three cycles after a select write or after sensing is re-enabled, with no pin having moved. A wrong source mux shows up as a flag pattern that follows the wrong pin on the very next pin change. A corrupted flag register shows up at once on `irq` and in the flag read. The random passes check every line's flag against a model after each pin change, so a single-line fault is seen within one pass.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
   localparam int unsigned OFS_SEL_LO = 32'h100;
   localparam int unsigned OFS_SEL_HI = 32'h104;
   localparam int unsigned OFS_RISE   = 32'h108;
   localparam int unsigned OFS_FALL   = 32'h10C;
   localparam int unsigned OFS_IEN    = 32'h110;
   localparam int unsigned OFS_FLAGS  = 32'h114;
   localparam int unsigned OFS_FSET   = 32'h118;
   localparam int unsigned OFS_FCLR   = 32'h11C;
   localparam int unsigned OFS_SENSE  = 32'h124;

   localparam int unsigned SENSE_IRQ_BIT = 0;
   localparam int unsigned SENSE_EVT_BIT = 1;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
   parameter int unsigned WIDTH  = 96,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("extirq_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_in;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/extirq_line.sv
module extirq_line #(
   parameter int unsigned NUM_PORTS = 6,
   parameter int unsigned SEL_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SEL_W-1:0]     sel,
   input  logic [NUM_PORTS-1:0] pin_cand,
   input  logic                 sense_en,
   input  logic                 rise_en,
   input  logic                 fall_en,
   output logic                 hit,
   output logic                 level
);
   logic             cur;
   logic             prev_q;
   logic [SEL_W-1:0] sel_seen_q;
   logic             reload;
   logic             rise_seen;
   logic             fall_seen;

   // codes past the last port leave the line parked low
   always_comb begin
      cur = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (sel == SEL_W'(p)) cur = pin_cand[p];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q     <= 1'b0;
         sel_seen_q <= '0;
      end else begin
         prev_q     <= cur;
         sel_seen_q <= sel;
      end
   end

   // a source change blanks the compare for one cycle while history reloads
   assign reload    = (sel != sel_seen_q);
   assign rise_seen = cur & ~prev_q;
   assign fall_seen = ~cur & prev_q;
   assign hit       = sense_en & ~reload & ((rise_seen & rise_en) | (fall_seen & fall_en));
   assign level     = cur;
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
   import extirq_pkg::*;
#(
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned SEL_W     = 4,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                bus_we,
   input  logic [ADDR_W-1:0]                   bus_addr,
   input  logic [DATA_W-1:0]                   bus_wdata,
   output logic [DATA_W-1:0]                   bus_rdata,
   input  logic [NUM_LINES-1:0]                line_hit,
   output logic [NUM_LINES-1:0][SEL_W-1:0]     sel_q,
   output logic [NUM_LINES-1:0]                rise_q,
   output logic [NUM_LINES-1:0]                fall_q,
   output logic [NUM_LINES-1:0]                ien_q,
   output logic [NUM_LINES-1:0]                flags_q,
   output logic [1:0]                          sense_q
);
   localparam int unsigned LPW = DATA_W / SEL_W;

   generate
      if (NUM_LINES > 2 * LPW) begin : g_bad_lines
         $error("extirq_regs: two select words cannot hold NUM_LINES fields");
      end
      if (NUM_LINES > DATA_W) begin : g_bad_width
         $error("extirq_regs: NUM_LINES exceeds the data width");
      end
   endgenerate

   logic hit_lo, hit_hi, hit_rise, hit_fall, hit_ien, hit_set, hit_clr, hit_sense, hit_flags;

   assign hit_lo    = (bus_addr == ADDR_W'(OFS_SEL_LO));
   assign hit_hi    = (bus_addr == ADDR_W'(OFS_SEL_HI));
   assign hit_rise  = (bus_addr == ADDR_W'(OFS_RISE));
   assign hit_fall  = (bus_addr == ADDR_W'(OFS_FALL));
   assign hit_ien   = (bus_addr == ADDR_W'(OFS_IEN));
   assign hit_flags = (bus_addr == ADDR_W'(OFS_FLAGS));
   assign hit_set   = (bus_addr == ADDR_W'(OFS_FSET));
   assign hit_clr   = (bus_addr == ADDR_W'(OFS_FCLR));
   assign hit_sense = (bus_addr == ADDR_W'(OFS_SENSE));

   logic [NUM_LINES-1:0] set_mask;
   logic [NUM_LINES-1:0] clr_mask;

   assign set_mask = (bus_we && hit_set) ? bus_wdata[NUM_LINES-1:0] : '0;
   assign clr_mask = (bus_we && hit_clr) ? bus_wdata[NUM_LINES-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         rise_q  <= '0;
         fall_q  <= '0;
         ien_q   <= '0;
         sense_q <= '0;
      end else if (bus_we) begin
         for (int l = 0; l < NUM_LINES; l++) begin
            if ((l < LPW) ? hit_lo : hit_hi) begin
               sel_q[l] <= bus_wdata[(l % LPW)*SEL_W +: SEL_W];
            end
         end
         if (hit_rise)  rise_q  <= bus_wdata[NUM_LINES-1:0];
         if (hit_fall)  fall_q  <= bus_wdata[NUM_LINES-1:0];
         if (hit_ien)   ien_q   <= bus_wdata[NUM_LINES-1:0];
         if (hit_sense) sense_q <= bus_wdata[1:0];
      end
   end

   // hardware edges are OR-ed in after the clear, so they win a collision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else begin
         flags_q <= ((flags_q | set_mask) & ~clr_mask) | line_hit;
      end
   end

   logic [DATA_W-1:0] sel_lo_word;
   logic [DATA_W-1:0] sel_hi_word;

   always_comb begin
      sel_lo_word = '0;
      sel_hi_word = '0;
      for (int l = 0; l < NUM_LINES; l++) begin
         if (l < LPW) sel_lo_word[(l % LPW)*SEL_W +: SEL_W] = sel_q[l];
         else         sel_hi_word[(l % LPW)*SEL_W +: SEL_W] = sel_q[l];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_lo)         bus_rdata = sel_lo_word;
      else if (hit_hi)    bus_rdata = sel_hi_word;
      else if (hit_rise)  bus_rdata[NUM_LINES-1:0] = rise_q;
      else if (hit_fall)  bus_rdata[NUM_LINES-1:0] = fall_q;
      else if (hit_ien)   bus_rdata[NUM_LINES-1:0] = ien_q;
      else if (hit_flags) bus_rdata[NUM_LINES-1:0] = flags_q;
      else if (hit_sense) bus_rdata[1:0] = sense_q;
   end
endmodule

// File: rtl/extirq_unit.sv
module extirq_unit
   import extirq_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 16,
   parameter int unsigned NUM_PORTS   = 6,
   parameter int unsigned PORT_W      = 16,
   parameter int unsigned SEL_W       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS*PORT_W-1:0] pins_in,
   input  logic                        bus_we,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   output logic                        irq,
   output logic [NUM_LINES-1:0]        evt_level
);
   localparam int unsigned PIN_BITS = NUM_PORTS * PORT_W;

   generate
      if (NUM_LINES > PORT_W) begin : g_bad_port_w
         $error("extirq_unit: each line needs a pin of the same number");
      end
      if (NUM_PORTS > (1 << SEL_W)) begin : g_bad_sel_w
         $error("extirq_unit: SEL_W too narrow for NUM_PORTS");
      end
   endgenerate

   logic [PIN_BITS-1:0]               pins_sync;
   logic [NUM_LINES-1:0][SEL_W-1:0]   sel_q;
   logic [NUM_LINES-1:0]              rise_q;
   logic [NUM_LINES-1:0]              fall_q;
   logic [NUM_LINES-1:0]              ien_q;
   logic [NUM_LINES-1:0]              flags_q;
   logic [1:0]                        sense_q;
   logic [NUM_LINES-1:0]              line_hit;
   logic [NUM_LINES-1:0]              line_level;

   extirq_sync #(
      .WIDTH  (PIN_BITS),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pins_in),
      .d_out (pins_sync)
   );

   extirq_regs #(
      .NUM_LINES (NUM_LINES),
      .SEL_W     (SEL_W),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .line_hit  (line_hit),
      .sel_q     (sel_q),
      .rise_q    (rise_q),
      .fall_q    (fall_q),
      .ien_q     (ien_q),
      .flags_q   (flags_q),
      .sense_q   (sense_q)
   );

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic [NUM_PORTS-1:0] cand;
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cand
         assign cand[p] = pins_sync[p*PORT_W + l];
      end

      extirq_line #(
         .NUM_PORTS (NUM_PORTS),
         .SEL_W     (SEL_W)
      ) i_line (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel      (sel_q[l]),
         .pin_cand (cand),
         .sense_en (sense_q[SENSE_IRQ_BIT]),
         .rise_en  (rise_q[l]),
         .fall_en  (fall_q[l]),
         .hit      (line_hit[l]),
         .level    (line_level[l])
      );
   end

   assign irq       = |(flags_q & ien_q);
   assign evt_level = line_level & {NUM_LINES{sense_q[SENSE_EVT_BIT]}};
endmodule

// File: rtl/extirq_chk.sv
module extirq_chk
   import extirq_pkg::*;
#(
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned NUM_PORTS = 6,
   parameter int unsigned SEL_W     = 4,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            bus_we,
   input logic [ADDR_W-1:0]               bus_addr,
   input logic [DATA_W-1:0]               bus_wdata,
   input logic                            irq,
   input logic [NUM_LINES-1:0]            evt_level,
   input logic [NUM_LINES-1:0][SEL_W-1:0] sel_q,
   input logic [NUM_LINES-1:0]            ien_q,
   input logic [NUM_LINES-1:0]            flags_q,
   input logic [1:0]                      sense_q,
   input logic [NUM_LINES-1:0]            line_hit
);
   logic [NUM_LINES-1:0] no_source;
   logic                 set_wr;
   logic                 clr_wr;

   always_comb begin
      for (int l = 0; l < NUM_LINES; l++) begin
         no_source[l] = (sel_q[l] >= SEL_W'(NUM_PORTS));
      end
   end

   assign set_wr = bus_we && (bus_addr == ADDR_W'(OFS_FSET));
   assign clr_wr = bus_we && (bus_addr == ADDR_W'(OFS_FCLR));

   a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien_q != '0));

   a_r9_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
      set_wr |=> ((flags_q & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0])));

   a_r9_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((flags_q & $past(bus_wdata[NUM_LINES-1:0]) & ~$past(line_hit)) == '0));

   a_r10_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (line_hit != '0) |=> ((flags_q & $past(line_hit)) == $past(line_hit)));

   a_r8_sense_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !sense_q[SENSE_IRQ_BIT] |-> (line_hit == '0));

   a_r6_no_source_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      ((line_hit & no_source) == '0));

   a_r12_evt_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !sense_q[SENSE_EVT_BIT] |-> (evt_level == '0));

   a_r11_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_wr && !clr_wr && line_hit == '0) |=> $stable(flags_q));
endmodule

bind extirq_unit extirq_chk #(
   .NUM_LINES (NUM_LINES),
   .NUM_PORTS (NUM_PORTS),
   .SEL_W     (SEL_W),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W)
) i_extirq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .evt_level (evt_level),
   .sel_q     (sel_q),
   .ien_q     (ien_q),
   .flags_q   (flags_q),
   .sense_q   (sense_q),
   .line_hit  (line_hit)
);

// File: tb/test_extirq_unit.sv
module test_extirq_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 16;
   localparam int NP = 6;
   localparam int PW = 16;

   localparam logic [11:0] A_SEL_LO = 12'h100;
   localparam logic [11:0] A_SEL_HI = 12'h104;
   localparam logic [11:0] A_RISE   = 12'h108;
   localparam logic [11:0] A_FALL   = 12'h10C;
   localparam logic [11:0] A_IEN    = 12'h110;
   localparam logic [11:0] A_FLAGS  = 12'h114;
   localparam logic [11:0] A_FSET   = 12'h118;
   localparam logic [11:0] A_FCLR   = 12'h11C;
   localparam logic [11:0] A_SENSE  = 12'h124;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NP*PW-1:0] pins = '0;
   logic             bus_we = 1'b0;
   logic [11:0]      bus_addr = '0;
   logic [31:0]      bus_wdata = '0;
   logic [31:0]      bus_rdata;
   logic             irq;
   logic [NL-1:0]    evt_level;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   extirq_unit i_extirq_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins_in   (pins),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq),
      .evt_level (evt_level)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // drive pins away from the edge, then let sync + detect + latch pass
   task automatic drive_pins(input logic [NP*PW-1:0] v);
      @(negedge clk);
      pins = v;
      repeat (4) @(posedge clk);
   endtask

   function automatic logic [NL-1:0] model_flags(input logic [NP*PW-1:0] old_p,
                                                  input logic [NP*PW-1:0] new_p,
                                                  input logic [NL-1:0][3:0] sel,
                                                  input logic [NL-1:0] rise,
                                                  input logic [NL-1:0] fall);
      logic [NL-1:0] r = '0;
      for (int l = 0; l < NL; l++) begin
         if (sel[l] < NP) begin
            logic o, n;
            o = old_p[sel[l]*PW + l];
            n = new_p[sel[l]*PW + l];
            if ((!o && n && rise[l]) || (o && !n && fall[l])) r[l] = 1'b1;
         end
      end
      return r;
   endfunction

   function automatic logic [NL-1:0] model_level(input logic [NP*PW-1:0] p,
                                                  input logic [NL-1:0][3:0] sel);
      logic [NL-1:0] r = '0;
      for (int l = 0; l < NL; l++) begin
         if (sel[l] < NP) r[l] = p[sel[l]*PW + l];
      end
      return r;
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic [NL-1:0][3:0] sel;
      logic [NL-1:0] rise, fall, ien, expf;
      logic [NP*PW-1:0] old_p, new_p;

      void'($urandom(32'h5eed_0042));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset values
      rd(A_SEL_LO, d); chk("R1 sel lo", d, 0);
      rd(A_SEL_HI, d); chk("R1 sel hi", d, 0);
      rd(A_RISE, d);   chk("R1 rise", d, 0);
      rd(A_IEN, d);    chk("R1 ien", d, 0);
      rd(A_FLAGS, d);  chk("R1 flags", d, 0);
      rd(A_SENSE, d);  chk("R1 sense", d, 0);
      chk("R1 irq", {31'b0, irq}, 0);
      chk("R1 evt", {16'b0, evt_level}, 0);

      // R2 readback and ignored flag write
      wr(A_SEL_LO, 32'h7654_3210); rd(A_SEL_LO, d); chk("R2 sel lo", d, 32'h7654_3210);
      wr(A_SEL_HI, 32'hFEDC_BA98); rd(A_SEL_HI, d); chk("R2 sel hi", d, 32'hFEDC_BA98);
      wr(A_FALL, 32'h0000_A5A5);   rd(A_FALL, d);   chk("R2 fall", d, 32'h0000_A5A5);
      wr(A_SENSE, 32'h3);          rd(A_SENSE, d);  chk("R2 sense", d, 32'h3);
      wr(A_FLAGS, 32'h0000_FFFF);  rd(A_FLAGS, d);  chk("R2 flag write ignored", d, 0);
      wr(A_SEL_LO, 0); wr(A_SEL_HI, 0); wr(A_FALL, 0);
      wr(A_SENSE, 32'h1);

      // R9 set and clear aliases
      wr(A_FSET, 32'h00A5); rd(A_FLAGS, d); chk("R9 set", d, 32'h00A5);
      wr(A_FSET, 32'h0000); rd(A_FLAGS, d); chk("R9 set zeros", d, 32'h00A5);
      wr(A_FCLR, 32'h0005); rd(A_FLAGS, d); chk("R9 clr", d, 32'h00A0);
      wr(A_FCLR, 32'h0000); rd(A_FLAGS, d); chk("R9 clr zeros", d, 32'h00A0);
      wr(A_FCLR, 32'hFFFF);

      // R3 rise on port 0, R5 edge without its enable
      wr(A_RISE, 32'h0001);
      drive_pins(96'h0003);
      rd(A_FLAGS, d); chk("R3 rise port0 line0 / R5 line1 unarmed", d, 32'h0001);
      // R4 fall only
      wr(A_FCLR, 32'hFFFF); wr(A_RISE, 0); wr(A_FALL, 32'h0002);
      drive_pins(96'h0000);
      rd(A_FLAGS, d); chk("R4 fall line1 / R5 line0 unarmed", d, 32'h0002);
      wr(A_FCLR, 32'hFFFF);

      // R11 latch with enable clear, then irq on enable
      wr(A_RISE, 32'hFFFF); wr(A_FALL, 32'hFFFF);
      drive_pins(96'h0004);
      rd(A_FLAGS, d); chk("R11 latched with ien clear", d, 32'h0004);
      chk("R11 irq low", {31'b0, irq}, 0);
      wr(A_IEN, 32'h0004); #1 chk("R11 irq high", {31'b0, irq}, 1);
      wr(A_IEN, 0);

      // R10 edge collides with clear on line 2 (pin falls)
      @(negedge clk) pins = 96'h0000;
      @(posedge clk); @(posedge clk);
      @(negedge clk); bus_we = 1'b1; bus_addr = A_FCLR; bus_wdata = 32'h0004;
      @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
      rd(A_FLAGS, d); chk("R10 set beats clear", d, 32'h0004);
      wr(A_FCLR, 32'hFFFF);

      // R7 select change onto a port with a different level
      drive_pins({16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0008, 16'h0000});
      wr(A_FCLR, 32'hFFFF);
      wr(A_SEL_LO, 32'h0000_1000);
      repeat (4) @(posedge clk);
      rd(A_FLAGS, d); chk("R7 no flag on select change", d, 0);
      // R12 event level follows the selected port
      wr(A_SENSE, 32'h3);
      #1 chk("R12 evt level", {16'b0, evt_level}, 32'h0008);
      wr(A_SENSE, 32'h1);
      #1 chk("R12 evt gated", {16'b0, evt_level}, 0);

      // R6 code 7 connects nothing
      wr(A_SEL_LO, 32'h0000_7000);
      drive_pins(96'h0);
      drive_pins({6{16'h0008}});
      rd(A_FLAGS, d); chk("R6 code 7 no flag", d, 0);

      // R8 sensing off
      wr(A_SEL_LO, 0); drive_pins(96'h0);
      wr(A_FCLR, 32'hFFFF); wr(A_SENSE, 0);
      drive_pins({6{16'hFFFF}});
      rd(A_FLAGS, d); chk("R8 sense off", d, 0);
      wr(A_SENSE, 32'h1);
      repeat (4) @(posedge clk);
      rd(A_FLAGS, d); chk("R8 re-enable no flag", d, 0);

      // random passes: R3 R4 R5 R6 R11
      old_p = pins;
      for (int it = 0; it < 40; it++) begin
         for (int l = 0; l < NL; l++) sel[l] = 4'($urandom_range(0, 7));
         rise = 16'($urandom); fall = 16'($urandom); ien = 16'($urandom);
         wr(A_SEL_LO, sel[7:0]); wr(A_SEL_HI, sel[15:8]);
         wr(A_RISE, {16'b0, rise}); wr(A_FALL, {16'b0, fall});
         wr(A_IEN, {16'b0, ien});
         repeat (2) @(posedge clk);
         wr(A_FCLR, 32'hFFFF);
         new_p = {$urandom, $urandom, $urandom};
         drive_pins(new_p);
         expf = model_flags(old_p, new_p, sel, rise, fall);
         rd(A_FLAGS, d); chk("R3/R4/R5/R6 random flags", d, {16'b0, expf});
         chk("R11 random irq", {31'b0, irq}, {31'b0, |(expf & ien)});
         if (it % 8 == 0) begin
            wr(A_SENSE, 32'h3);
            #1 chk("R12 random level", {16'b0, evt_level}, {16'b0, model_level(new_p, sel)});
            wr(A_SENSE, 32'h1);
         end
         old_p = new_p;
      end

      finish_run();
   end
endmodule